// File: doc/BRIEF.md
# Victim Line Store for a Direct-Mapped Cache

This block is a small, fully associative side store that sits beside a direct-mapped cache and holds lines that cache has recently thrown out. Every entry carries its full block address as a tag plus valid and dirty bits, and all tags are compared in parallel. The store is only looked up after the main cache has missed. The main cache presents the missing block address on the probe port, together with the line it is about to displace. On a hit, the stored line comes back in the same cycle so the main cache can refill from it. The displaced line is written into the entry that just hit, so the two lines trade places.

When the main cache refills from lower memory instead, it pushes its displaced line in through the insert port. The line goes into a free entry if there is one. Otherwise it overwrites the entry that has gone longest without being inserted or swapped into. If that overwritten entry is dirty, it goes out on the writeback port one cycle later. A probe and an insert may arrive in the same cycle. The swap is applied first and the insert is matched against the result, so one block address never occupies two entries.

Top module: `victim_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid: no probe hits and `wb_valid` is low.
- R2: When `probe_valid` is high and a valid entry's tag equals `probe_addr`, `probe_hit` is high in the same cycle and `probe_data`/`probe_dirty` give that entry's line and dirty bit.
- R3: A probe with no matching entry gives `probe_hit` low and leaves every entry unchanged.
- R4: On a probe hit, the hitting entry takes the displaced line (`swap_addr`, `swap_data`, `swap_dirty`) at the clock edge when `swap_valid` is high, and becomes invalid when it is low.
- R5: An insert whose address is not stored goes into a free entry when one exists, and produces no writeback.
- R6: An insert into a full store replaces the entry least recently inserted into or swapped into. That entry's address and data appear on `wb_addr`/`wb_data` with `wb_valid` high in the next cycle if it was dirty, and it is dropped silently if it was clean.
- R7: An insert whose address is already stored overwrites that entry in place with the new data and the OR of both dirty bits, and evicts nothing.
- R8: When a probe and an insert share a cycle, the swap takes effect first and the insert is matched against the swapped contents, so no block address is ever held by two valid entries.
- R9: `wb_valid` is high only in the cycle after an insert that evicted a dirty entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_valid | input | 1 | Main cache missed; search for `probe_addr` |
| probe_addr | input | AW | Block address being searched |
| probe_hit | output | 1 | Search found a valid matching entry (same cycle) |
| probe_data | output | LW | Line data of the hitting entry |
| probe_dirty | output | 1 | Dirty bit of the hitting entry |
| swap_valid | input | 1 | A displaced line accompanies the probe |
| swap_addr | input | AW | Block address of the displaced line |
| swap_data | input | LW | Data of the displaced line |
| swap_dirty | input | 1 | Dirty bit of the displaced line |
| ins_valid | input | 1 | Insert a line evicted from the main cache |
| ins_addr | input | AW | Block address of the inserted line |
| ins_data | input | LW | Data of the inserted line |
| ins_dirty | input | 1 | Dirty bit of the inserted line |
| wb_valid | output | 1 | Dirty line pushed out toward lower memory |
| wb_addr | output | AW | Block address of the written-back line |
| wb_data | output | LW | Data of the written-back line |

## Verification
The bench aims at the cases where ordering decides the result. One is a same-cycle probe and insert in which the inserted address equals the displaced one; a design that ignored the swap would keep two copies, and later probes would see stale data. Another is eviction after a mix of swaps and inserts, where a replacement order that forgot swaps count as uses would write back the wrong line. A third is a probe with the swap line absent, which must free the entry so the next insert causes no writeback. It also re-inserts an already stored address: getting this wrong would evict a neighbour or clear a dirty bit, and the result shows up as a missing or extra writeback.

// File: rtl/victim_cache_pkg.sv
// Package: defaults and helpers shared by the victim store modules.
// Assumes nothing beyond elaboration-time integer arithmetic.
package victim_cache_pkg;
    localparam int VC_ENTRIES_DEF = 4;
    localparam int VC_ADDR_W_DEF  = 26;
    localparam int VC_LINE_W_DEF  = 64;

    // Index width for n entries, never below one bit.
    function automatic int vc_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vc_tag_match.sv
// Module: parallel tag comparators, one per entry.
// Assumes tags are packed entry 0 in the low bits; output bit i set when
// entry i is valid, the search is enabled and its tag equals the key.
module vc_tag_match #(
    parameter int N  = 4,
    parameter int AW = 26
) (
    input  logic            en,
    input  logic [AW-1:0]   key,
    input  logic [N-1:0]    valid,
    input  logic [N*AW-1:0] tags_flat,
    output logic [N-1:0]    hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // One comparator per entry.
        assign hit_vec[i] = en && valid[i] && (tags_flat[i*AW +: AW] == key);
    end
endmodule

// File: rtl/vc_pick_first.sv
// Module: encodes a request vector into the index of its lowest set bit.
// Assumes the caller qualifies the index with its own OR of the vector;
// with no bit set the index is zero.
module vc_pick_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vc_lru_rank.sv
// Module: recency ranks for the entries; rank 0 is newest, N-1 oldest.
// Two touches per cycle are applied in order (first then second). The
// oldest one-hot reflects the ranks after the first touch, so a same-cycle
// insert never picks the entry that was just swapped into.
// Assumes ranks start as a permutation and stay one.
module vc_lru_rank #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ta_en,
    input  logic [IW-1:0] ta_idx,
    input  logic          tb_en,
    input  logic [IW-1:0] tb_idx,
    output logic [N-1:0]  oldest_oh
);
    logic [IW-1:0] rank_q [N];
    logic [IW-1:0] r1     [N];
    logic [IW-1:0] r2     [N];

    // Apply the probe touch, then the insert touch.
    always_comb begin
        r1 = rank_q;
        if (ta_en) begin
            for (int j = 0; j < N; j++) begin
                if (rank_q[j] < rank_q[ta_idx]) r1[j] = rank_q[j] + 1'b1;
            end
            r1[ta_idx] = '0;
        end
        r2 = r1;
        if (tb_en) begin
            for (int j = 0; j < N; j++) begin
                if (r1[j] < r1[tb_idx]) r2[j] = r1[j] + 1'b1;
            end
            r2[tb_idx] = '0;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_old
        // Entry holding the highest rank after the first touch.
        assign oldest_oh[i] = (r1[i] == IW'(N - 1));
    end

    // Rank registers; reset to the identity permutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else begin
            rank_q <= r2;
        end
    end
endmodule

// File: rtl/victim_cache.sv
// Module: fully associative victim store beside a direct-mapped cache.
// Probe (on a main miss) returns a hit line combinationally and swaps in
// the displaced line at the clock edge. Insert places an evicted line into
// a matching, free or least recently used entry; a dirty line pushed out
// appears on the writeback port one cycle later.
// Assumes the displaced line on a probe is never already held elsewhere.
module victim_cache
    import victim_cache_pkg::*;
#(
    parameter int N  = VC_ENTRIES_DEF,
    parameter int AW = VC_ADDR_W_DEF,
    parameter int LW = VC_LINE_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          probe_valid,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic [LW-1:0] probe_data,
    output logic          probe_dirty,
    input  logic          swap_valid,
    input  logic [AW-1:0] swap_addr,
    input  logic [LW-1:0] swap_data,
    input  logic          swap_dirty,
    input  logic          ins_valid,
    input  logic [AW-1:0] ins_addr,
    input  logic [LW-1:0] ins_data,
    input  logic          ins_dirty,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [LW-1:0] wb_data
);
    localparam int IW = vc_idx_w(N);

    logic [N-1:0]  valid_q, dirty_q;
    logic [AW-1:0] tag_q  [N];
    logic [LW-1:0] data_q [N];

    logic [N-1:0]  mid_valid, mid_dirty;
    logic [AW-1:0] mid_tag  [N];
    logic [LW-1:0] mid_data [N];

    logic [N-1:0]  nxt_valid, nxt_dirty;
    logic [AW-1:0] nxt_tag  [N];
    logic [LW-1:0] nxt_data [N];

    logic [N*AW-1:0] tag_flat, mid_tag_flat;
    logic [N-1:0]    probe_vec, ins_vec, oldest_oh;
    logic [IW-1:0]   probe_idx, merge_idx, free_idx, old_idx, ins_tgt;
    logic            probe_any, ins_merge, free_any, evict;

    for (genvar i = 0; i < N; i++) begin : g_flat
        // Flatten stored and post-swap tags for the comparators.
        assign tag_flat[i*AW +: AW]     = tag_q[i];
        assign mid_tag_flat[i*AW +: AW] = mid_tag[i];
    end

    vc_tag_match #(.N(N), .AW(AW)) u_probe_match (
        .en(probe_valid), .key(probe_addr), .valid(valid_q),
        .tags_flat(tag_flat), .hit_vec(probe_vec)
    );
    vc_pick_first #(.N(N), .IW(IW)) u_probe_pick (.req(probe_vec), .idx(probe_idx));

    assign probe_any   = |probe_vec;
    assign probe_hit   = probe_any;
    assign probe_data  = probe_any ? data_q[probe_idx] : '0;
    assign probe_dirty = probe_any && dirty_q[probe_idx];

    // Contents after the probe swap, before the insert.
    always_comb begin
        mid_valid = valid_q;
        mid_dirty = dirty_q;
        mid_tag   = tag_q;
        mid_data  = data_q;
        if (probe_any) begin
            if (swap_valid) begin
                mid_valid[probe_idx] = 1'b1;
                mid_dirty[probe_idx] = swap_dirty;
                mid_tag[probe_idx]   = swap_addr;
                mid_data[probe_idx]  = swap_data;
            end else begin
                mid_valid[probe_idx] = 1'b0;
            end
        end
    end

    vc_tag_match #(.N(N), .AW(AW)) u_ins_match (
        .en(ins_valid), .key(ins_addr), .valid(mid_valid),
        .tags_flat(mid_tag_flat), .hit_vec(ins_vec)
    );
    vc_pick_first #(.N(N), .IW(IW)) u_merge_pick (.req(ins_vec), .idx(merge_idx));
    vc_pick_first #(.N(N), .IW(IW)) u_free_pick (.req(~mid_valid), .idx(free_idx));
    vc_pick_first #(.N(N), .IW(IW)) u_old_pick (.req(oldest_oh), .idx(old_idx));

    vc_lru_rank #(.N(N), .IW(IW)) u_rank (
        .clk(clk), .rst_n(rst_n),
        .ta_en(probe_any), .ta_idx(probe_idx),
        .tb_en(ins_valid), .tb_idx(ins_tgt),
        .oldest_oh(oldest_oh)
    );

    assign ins_merge = |ins_vec;
    assign free_any  = ~&mid_valid;
    assign ins_tgt   = ins_merge ? merge_idx : (free_any ? free_idx : old_idx);
    assign evict     = ins_valid && !ins_merge && !free_any;

    // Contents after the insert.
    always_comb begin
        nxt_valid = mid_valid;
        nxt_dirty = mid_dirty;
        nxt_tag   = mid_tag;
        nxt_data  = mid_data;
        if (ins_valid) begin
            nxt_valid[ins_tgt] = 1'b1;
            nxt_dirty[ins_tgt] = ins_dirty || (ins_merge && mid_dirty[ins_tgt]);
            nxt_tag[ins_tgt]   = ins_addr;
            nxt_data[ins_tgt]  = ins_data;
        end
    end

    // Control state and writeback strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            dirty_q  <= '0;
            wb_valid <= 1'b0;
        end else begin
            valid_q  <= nxt_valid;
            dirty_q  <= nxt_dirty;
            wb_valid <= evict && mid_dirty[old_idx];
        end
    end

    // Tag, data and writeback payload; qualified by the valid bits.
    always_ff @(posedge clk) begin
        tag_q   <= nxt_tag;
        data_q  <= nxt_data;
        wb_addr <= mid_tag[old_idx];
        wb_data <= mid_data[old_idx];
    end
endmodule

// File: rtl/victim_cache_checker.sv
// Module: temporal checks on the victim store, bound into every instance.
// Assumes the displaced line on a probe is not already held.
module victim_cache_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         probe_valid,
    input logic         probe_hit,
    input logic         swap_valid,
    input logic         ins_valid,
    input logic         wb_valid,
    input logic [N-1:0] valid_q,
    input logic [N-1:0] probe_vec,
    input logic         ins_merge,
    input logic         free_any,
    input logic [N-1:0] oldest_oh
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!wb_valid && valid_q == '0));

    p_miss_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && !probe_hit && !ins_valid) |=> $stable(valid_q));

    p_free_on_empty_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_hit && !swap_valid && !ins_valid)
        |=> $countones(valid_q) == $countones($past(valid_q)) - 1);

    p_fill_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !probe_hit && !ins_merge && free_any)
        |=> $countones(valid_q) == $countones($past(valid_q)) + 1);

    p_one_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_oh) == 1);

    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(probe_vec) <= 1);

    p_wb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ins_valid));
endmodule

bind victim_cache victim_cache_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_hit(probe_hit),
    .swap_valid(swap_valid), .ins_valid(ins_valid), .wb_valid(wb_valid),
    .valid_q(valid_q), .probe_vec(probe_vec), .ins_merge(ins_merge),
    .free_any(free_any), .oldest_oh(oldest_oh)
);

// File: tb/victim_cache_test.sv
// Bench: directed corner cases then seeded random traffic, checked against
// a behavioural model of the store kept in bench arrays.
module victim_cache_test;
    localparam int N  = 4;
    localparam int AW = 26;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          probe_valid = 1'b0, swap_valid = 1'b0, swap_dirty = 1'b0;
    logic          ins_valid = 1'b0, ins_dirty = 1'b0;
    logic [AW-1:0] probe_addr = '0, swap_addr = '0, ins_addr = '0;
    logic [LW-1:0] swap_data = '0, ins_data = '0;
    logic          probe_hit, probe_dirty, wb_valid;
    logic [LW-1:0] probe_data, wb_data;
    logic [AW-1:0] wb_addr;

    int checks = 0, fails = 0, stamp = 0;
    bit done = 0;

    bit            m_valid [N];
    bit            m_dirty [N];
    int            m_tag   [N];
    logic [LW-1:0] m_data  [N];
    int            m_stamp [N];

    victim_cache #(.N(N), .AW(AW), .LW(LW)) uut (.*);

    always #10 clk = ~clk;

    task automatic chk(bit ok, string tag, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(int a);
        for (int e = 0; e < N; e++) if (m_valid[e] && m_tag[e] == a) return e;
        return -1;
    endfunction

    task automatic step(string lbl, bit pv, int pa, bit sv, int sa, logic [LW-1:0] sd, bit sdy,
                        bit iv, int ia, logic [LW-1:0] idt, bit idy);
        int h, t;
        bit ewb;
        int ewa;
        logic [LW-1:0] ewd;
        string tg;
        @(negedge clk);
        probe_valid = pv; probe_addr = AW'(pa);
        swap_valid = sv; swap_addr = AW'(sa); swap_data = sd; swap_dirty = sdy;
        ins_valid = iv; ins_addr = AW'(ia); ins_data = idt; ins_dirty = idy;
        #2;
        h = pv ? find(pa) : -1;
        tg = (lbl != "") ? lbl : ((h >= 0) ? "R2" : "R3");
        chk(probe_hit == (h >= 0), tg, "probe_hit", LW'(probe_hit), LW'(h >= 0));
        if (h >= 0) begin
            chk(probe_data == m_data[h], tg, "probe_data", probe_data, m_data[h]);
            chk(probe_dirty == m_dirty[h], tg, "probe_dirty", LW'(probe_dirty), LW'(m_dirty[h]));
            if (sv) begin
                m_tag[h] = sa; m_data[h] = sd; m_dirty[h] = sdy; m_stamp[h] = ++stamp;
            end else begin
                m_valid[h] = 0;
            end
        end
        ewb = 0; ewa = 0; ewd = '0;
        if (iv) begin
            t = find(ia);
            if (t >= 0) begin
                m_dirty[t] = m_dirty[t] | idy;
            end else begin
                for (int e = N - 1; e >= 0; e--) if (!m_valid[e]) t = e;
                if (t < 0) begin
                    t = 0;
                    for (int e = 1; e < N; e++) if (m_stamp[e] < m_stamp[t]) t = e;
                    ewb = m_dirty[t]; ewa = m_tag[t]; ewd = m_data[t];
                end
                m_dirty[t] = idy;
            end
            m_valid[t] = 1; m_tag[t] = ia; m_data[t] = idt; m_stamp[t] = ++stamp;
        end
        @(posedge clk);
        #2;
        tg = (lbl != "") ? lbl : (ewb ? "R6" : "R9");
        chk(wb_valid == ewb, tg, "wb_valid", LW'(wb_valid), LW'(ewb));
        if (ewb) begin
            chk(wb_addr == AW'(ewa), tg, "wb_addr", LW'(wb_addr), LW'(ewa));
            chk(wb_data == ewd, tg, "wb_data", wb_data, ewd);
        end
    endtask

    task automatic probe(string lbl, int pa, bit sv, int sa, logic [LW-1:0] sd, bit sdy);
        step(lbl, 1, pa, sv, sa, sd, sdy, 0, 0, '0, 0);
    endtask

    task automatic insert(string lbl, int ia, logic [LW-1:0] idt, bit idy);
        step(lbl, 0, 0, 0, 0, '0, 0, 1, ia, idt, idy);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int pa, sa, ia, op;
        void'($urandom(32'd20240611));
        for (int e = 0; e < N; e++) begin
            m_valid[e] = 0; m_dirty[e] = 0; m_tag[e] = 0; m_data[e] = '0; m_stamp[e] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", LW'(wb_valid), '0);
        probe("R1", 5, 0, 0, '0, 0);
        probe("R1", 0, 0, 0, '0, 0);

        // Fill the empty store: no writeback expected.
        insert("R5", 1, 64'h100, 1);
        insert("R5", 2, 64'h200, 0);
        insert("R5", 3, 64'h300, 1);
        insert("R5", 4, 64'h400, 0);
        // Hit and swap, then hit the swapped-in line.
        probe("R2", 2, 1, 9, 64'h900, 0);
        probe("R4", 9, 1, 10, 64'h1000, 1);
        // Miss leaves contents alone; confirm with a later hit.
        probe("R3", 7, 1, 12, 64'h1200, 1);
        probe("R3", 3, 1, 11, 64'h1100, 0);
        // Full store: oldest is line 1 (dirty), then line 4 (clean).
        insert("R6", 20, 64'h2000, 0);
        insert("R6", 21, 64'h2100, 1);
        // Re-insert of a held address merges in place.
        insert("R7", 10, 64'h1111, 0);
        probe("R7", 10, 1, 12, 64'h1200, 0);
        // Same-cycle probe swap and insert of the displaced address.
        step("R8", 1, 11, 1, 13, 64'h1300, 0, 1, 13, 64'h1313, 1);
        probe("R8", 13, 1, 14, 64'h1400, 0);
        // Same-cycle probe swap and insert of the probed address.
        step("R8", 1, 20, 1, 15, 64'h1500, 1, 1, 20, 64'h2020, 0);
        probe("R8", 20, 1, 16, 64'h1600, 0);
        // Probe hit without a displaced line frees the entry.
        probe("R4", 21, 0, 0, '0, 0);
        insert("R5", 30, 64'h3000, 1);
        probe("R4", 21, 0, 0, '0, 0);

        for (int k = 0; k < 4000; k++) begin
            op = $urandom % 4;
            pa = $urandom % 16;
            ia = $urandom % 16;
            sa = $urandom % 16;
            while (find(sa) >= 0) sa = $urandom % 16;
            step("", op == 0 || op == 2, pa, ($urandom % 8) != 0, sa,
                 {$urandom, $urandom}, $urandom % 2,
                 op == 1 || op == 2, ia, {$urandom, $urandom}, $urandom % 2);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule